// File: doc/BRIEF.md
# Four-Channel PWM Generator with Register Access

This block generates four independent pulse-width-modulated outputs, configured through a small word-addressed register interface. Each channel has a two-stage timebase. A 16-bit divider counter produces a tick every N input clocks. Each tick advances an 8-bit phase counter, so a full output period is 256·N clocks. The channel output stays high while the phase is below an 8-bit level value, and low for the rest of the period. Each channel's level register also names which channel's divider tick drives its phase counter. This lets several outputs share one time base.

Software sets three bit groups in two mode words: per-channel output enables, per-channel force-high bits, and per-channel counter enables. New divider or level values act in the very next clock, with no wait for the end of the running period. The register port is a plain single-cycle interface. A write strobe commits on the clock edge. Read data is a combinational function of the address. There is no handshake and no back-pressure, because every access completes in one cycle.

Top module: `qpwm_top`

## Requirements
- R1: After reset every register reads zero, except that the select field (bits 9:8) of channel c's level register reads c. All outputs are low.
- R2: The register layout is as follows. Offset 0x00 holds the output enables in bits 3:0 and the force-high bits in bits 11:8. Offset 0x04 holds the counter enables in bits 3:0. Offset 0x08+4c holds the 16-bit divider of channel c. Offset 0x18+4c holds the level of channel c in bits 7:0 and its select field in bits 9:8. Reads return what was written, with unused bits reading zero.
- R3: An address not in the layout, including any address that is not a multiple of 4, reads zero. A write to such an address changes no register.
- R4: With the output and counter enabled and force-high clear, the output repeats with a period of 256·D clocks and is high for L·D clocks of each period. Here D is the divider value and L is the level.
- R5: A divider value of 0 behaves exactly as a value of 1.
- R6: A level of 0 gives a constant low output while force-high is clear.
- R7: When the output enable and the force-high bit are both set, the output is constantly high.
- R8: When the output enable is clear, the output is low, whatever the other settings are.
- R9: When the counter enable is clear, the channel's divider and phase counters are held at zero. An enabled output then stays high if its level is nonzero.
- R10: The select field picks which channel's divider tick advances this channel's phase counter.
- R11: A new level or divider value takes effect in the cycle after the write, without completing the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, committed on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 4 | Channel outputs, bit c is channel c |

## Verification
The bound checker checks three relations on every cycle for every channel: a disabled output is low, an enabled output with force-high set is high, and a stopped counter holds its phase at zero while a running one never moves its phase by more than one step. The bench alone can show the timing results. These are the period and high-time products over a sweep of divider and level values, the behaviour of a zero divider, borrowing another channel's tick, and the instant effect of a mid-period write. The register layout, the masking of unused bits and the handling of unmapped addresses are also shown by bench scenarios.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int NUM_CH   = 4;
  localparam int DIV_W    = 16;
  localparam int PHASE_W  = 8;
  localparam int SEL_W    = $clog2(NUM_CH);
  localparam int DATA_W   = 32;
  localparam int BYP_LSB  = 8;
  localparam int OFS_MODE0 = 'h00;
  localparam int OFS_MODE1 = 'h04;
  localparam int OFS_DIV0  = 'h08;
  localparam int OFS_LVL0  = 'h18;

  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [PHASE_W-1:0] level;
  } lvl_reg_t;
endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
  import qpwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            wr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_CH-1:0]               oen,
  output logic [NUM_CH-1:0]               byp,
  output logic [NUM_CH-1:0]               cen,
  output logic [NUM_CH-1:0][DIV_W-1:0]    div_val,
  output lvl_reg_t [NUM_CH-1:0]           lvl
);
  localparam int LVL_W = SEL_W + PHASE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oen <= '0;
      byp <= '0;
      cen <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        div_val[c]   <= '0;
        lvl[c].sel   <= SEL_W'(c);
        lvl[c].level <= '0;
      end
    end else if (wr) begin
      if (addr == ADDR_W'(OFS_MODE0)) begin
        oen <= wdata[NUM_CH-1:0];
        byp <= wdata[BYP_LSB +: NUM_CH];
      end
      if (addr == ADDR_W'(OFS_MODE1)) cen <= wdata[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ADDR_W'(OFS_DIV0 + 4 * c)) div_val[c] <= wdata[DIV_W-1:0];
        if (addr == ADDR_W'(OFS_LVL0 + 4 * c)) lvl[c] <= lvl_reg_t'(wdata[LVL_W-1:0]);
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_MODE0)) begin
      rdata[NUM_CH-1:0]        = oen;
      rdata[BYP_LSB +: NUM_CH] = byp;
    end
    if (addr == ADDR_W'(OFS_MODE1)) rdata[NUM_CH-1:0] = cen;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(OFS_DIV0 + 4 * c)) rdata[DIV_W-1:0] = div_val[c];
      if (addr == ADDR_W'(OFS_LVL0 + 4 * c)) rdata[LVL_W-1:0] = lvl[c];
    end
  end
endmodule

// File: rtl/qpwm_timebase.sv
module qpwm_timebase
  import qpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;
  logic             wrap;

  // a zero divider wraps every cycle, the same as a divider of one
  assign last = (div_val == '0) ? '0 : div_val - DIV_W'(1);
  // >= so that shrinking the divider mid-count wraps at once
  assign wrap = (cnt >= last);
  assign tick = en & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || wrap) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel
  import qpwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               step,
  input  logic               oen,
  input  logic               byp,
  input  logic [PHASE_W-1:0] level,
  output logic [PHASE_W-1:0] phase,
  output logic               pwm
);
  always_ff @(posedge clk) begin
    if (!rst_n || !en) phase <= '0;
    else if (step)     phase <= phase + PHASE_W'(1);
  end

  assign pwm = oen & (byp | (phase < level));
endmodule

// File: rtl/qpwm_top.sv
module qpwm_top
  import qpwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [3:0]        pwm_out
);
  logic [NUM_CH-1:0]               oen;
  logic [NUM_CH-1:0]               byp;
  logic [NUM_CH-1:0]               cen;
  logic [NUM_CH-1:0][DIV_W-1:0]    div_val;
  lvl_reg_t [NUM_CH-1:0]           lvl;
  logic [NUM_CH-1:0]               tick;
  logic [NUM_CH-1:0]               step;
  logic [NUM_CH-1:0][PHASE_W-1:0]  phase_all;

  qpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .oen(oen), .byp(byp), .cen(cen), .div_val(div_val), .lvl(lvl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qpwm_timebase u_tb (
      .clk(clk), .rst_n(rst_n), .en(cen[c]), .div_val(div_val[c]), .tick(tick[c])
    );

    // phase counter advances on the tick of the selected channel
    assign step[c] = tick[lvl[c].sel];

    qpwm_channel u_chn (
      .clk(clk), .rst_n(rst_n), .en(cen[c]), .step(step[c]), .oen(oen[c]),
      .byp(byp[c]), .level(lvl[c].level), .phase(phase_all[c]), .pwm(pwm_out[c])
    );
  end
endmodule

// File: rtl/qpwm_chk.sv
module qpwm_chk
  import qpwm_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic [3:0]                     pwm_out,
  input logic [NUM_CH-1:0]              oen,
  input logic [NUM_CH-1:0]              byp,
  input logic [NUM_CH-1:0]              cen,
  input logic [NUM_CH-1:0][PHASE_W-1:0] phase_all
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    // R8: disabled output drives low
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !oen[c] |-> !pwm_out[c]);
    // R7: force-high with enable gives a high output
    p_force_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (oen[c] && byp[c]) |-> pwm_out[c]);
    // R9: stopped counter holds the phase at zero
    p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cen[c] |=> (phase_all[c] == '0));
    // R4: a running phase moves by at most one step per clock
    p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cen[c] |=> (!cen[c] || phase_all[c] == $past(phase_all[c])
                  || phase_all[c] == $past(phase_all[c]) + PHASE_W'(1)));
  end
endmodule

bind qpwm_top qpwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .oen(oen), .byp(byp),
  .cen(cen), .phase_all(phase_all)
);

// File: tb/test_qpwm_top.sv
module test_qpwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qpwm_top i_qpwm_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // skip a partial period: wait for a fall, then a rise, then time high and low parts
  task automatic measure(input int ch, output int hi, output int per, output bit ok);
    bit prev, cur;
    int n;
    int lo;
    ok = 1; n = 0; hi = 0; lo = 0;
    @(negedge clk); cur = pwm_out[ch]; prev = cur;
    while (ok && !(prev && !cur)) begin
      @(negedge clk); prev = cur; cur = pwm_out[ch]; n++;
      if (n > 4000) ok = 0;
    end
    while (ok && !(!prev && cur)) begin
      @(negedge clk); prev = cur; cur = pwm_out[ch]; n++;
      if (n > 4000) ok = 0;
    end
    if (ok) begin
      hi = 1;
      forever begin @(negedge clk); if (!pwm_out[ch]) break; hi++; end
      lo = 1;
      forever begin @(negedge clk); if (pwm_out[ch]) break; lo++; end
    end
    per = hi + lo;
  endtask

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int hi, per, n, dv;
    bit ok;
    int divs[3] = '{0, 1, 3};
    int lvls[3] = '{1, 77, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(pwm_out == 4'h0, "R1 outputs", pwm_out, 0);
    for (int a = 0; a < 'h28; a += 4) begin
      rd_reg(8'(a), d);
      if (a >= 'h18) check(d == 32'((a - 'h18) / 4) << 8, "R1 reset read", d, ((a - 'h18) / 4) << 8);
      else           check(d == 0, "R1 reset read", d, 0);
    end

    // R2: readback with masking of unused bits
    for (int a = 0; a < 'h28; a += 4) begin
      wr_reg(8'(a), 32'hFFFF_FFFF);
      rd_reg(8'(a), d);
      if (a == 0)         check(d == 32'h0F0F, "R2 mode0", d, 32'h0F0F);
      else if (a == 4)    check(d == 32'h000F, "R2 mode1", d, 32'h000F);
      else if (a < 'h18)  check(d == 32'hFFFF, "R2 divider", d, 32'hFFFF);
      else                check(d == 32'h03FF, "R2 level", d, 32'h03FF);
    end
    wr_reg(8'h00, 32'h0000_0105);
    rd_reg(8'h00, d);
    check(d == 32'h0105, "R2 mode0 pattern", d, 32'h0105);

    // R3: unmapped addresses
    wr_reg(8'h28, 32'hFFFF_FFFF);
    rd_reg(8'h28, d); check(d == 0, "R3 read 0x28", d, 0);
    wr_reg(8'h02, 32'h0000_0000);
    rd_reg(8'h02, d); check(d == 0, "R3 read 0x02", d, 0);
    rd_reg(8'h00, d); check(d == 32'h0105, "R3 mode0 untouched", d, 32'h0105);
    rd_reg(8'h08, d); check(d == 32'hFFFF, "R3 divider untouched", d, 32'hFFFF);

    wr_reg(8'h00, 0); wr_reg(8'h04, 0);
    // R8: outputs low with enables clear even though levels are set
    count_high(0, 50, n); check(n == 0, "R8 disabled low", n, 0);

    // R4/R5: sweep of channels, dividers and levels
    for (int ch = 0; ch < 4; ch++) begin
      for (int di = 0; di < 3; di++) begin
        for (int li = 0; li < 3; li++) begin
          wr_reg(8'h00, 0); wr_reg(8'h04, 0);
          wr_reg(8'(8 + 4 * ch), 32'(divs[di]));
          wr_reg(8'('h18 + 4 * ch), 32'((ch << 8) | lvls[li]));
          wr_reg(8'h04, 32'(1 << ch));
          wr_reg(8'h00, 32'(1 << ch));
          measure(ch, hi, per, ok);
          dv = (divs[di] == 0) ? 1 : divs[di];
          check(ok, "R4 period seen", ok, 1);
          check(hi == lvls[li] * dv, divs[di] == 0 ? "R5 high time" : "R4 high time", hi, lvls[li] * dv);
          check(per == 256 * dv, divs[di] == 0 ? "R5 period" : "R4 period", per, 256 * dv);
        end
      end
    end

    // R6: level zero
    wr_reg(8'h00, 0); wr_reg(8'h04, 0);
    wr_reg(8'h10, 1); wr_reg(8'h20, 32'h0200);
    wr_reg(8'h04, 32'h4); wr_reg(8'h00, 32'h4);
    count_high(2, 600, n); check(n == 0, "R6 level zero low", n, 0);

    // R7: force high with level zero
    wr_reg(8'h00, 32'h0404);
    count_high(2, 600, n); check(n == 600, "R7 forced high", n, 600);
    // R8: force bit alone, output enable clear
    wr_reg(8'h00, 32'h0400);
    count_high(2, 100, n); check(n == 0, "R8 force without enable", n, 0);

    // R9: counter stopped, level nonzero -> steady high
    wr_reg(8'h00, 0); wr_reg(8'h04, 0);
    wr_reg(8'h0C, 1); wr_reg(8'h1C, 32'h0105);
    wr_reg(8'h00, 32'h2);
    count_high(1, 600, n); check(n == 600, "R9 stopped counter high", n, 600);

    // R10: channel 1 borrows channel 0's divider
    wr_reg(8'h00, 0); wr_reg(8'h04, 0);
    wr_reg(8'h08, 1); wr_reg(8'h0C, 4);
    wr_reg(8'h1C, 32'h000A);
    wr_reg(8'h04, 32'h3); wr_reg(8'h00, 32'h2);
    measure(1, hi, per, ok);
    check(hi == 10, "R10 borrowed high time", hi, 10);
    check(per == 256, "R10 borrowed period", per, 256);
    // stopping the borrowed source freezes the phase: output becomes steady
    wr_reg(8'h1C, 32'h0080);
    wr_reg(8'h04, 32'h2);
    count_high(1, 300, n);
    check(n == 0 || n == 300, "R10 source stopped steady", n, 300);

    // R11: mid-period level change
    wr_reg(8'h00, 0); wr_reg(8'h04, 0);
    wr_reg(8'h08, 1); wr_reg(8'h18, 32'd200);
    wr_reg(8'h04, 32'h1); wr_reg(8'h00, 32'h1);
    measure(0, hi, per, ok);
    repeat (19) @(negedge clk);
    check(pwm_out[0] == 1'b1, "R11 high before change", pwm_out[0], 1);
    wr_reg(8'h18, 32'd5);
    check(pwm_out[0] == 1'b0, "R11 low right after change", pwm_out[0], 0);
    measure(0, hi, per, ok);
    check(hi == 5, "R11 new high time", hi, 5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule